// File: doc/BRIEF.md
# Packet Timestamp Capture Latch

This block records the free-running system time at the moment a timing-protocol packet starts, on both the receive and the transmit paths. Each direction has its own one-deep latch. When a qualifying packet's start strobe arrives, the current 64-bit time value is stored and a valid flag is set. Software then reads the stored value as two 32-bit words. The latch stays locked until the high word is read, and any event packet that arrives while it is locked gets no timestamp.

On receive, a small classifier decides whether the packet qualifies. The classifier is fed by a simplified header interface: transport kind, ethertype, UDP destination port, protocol version and message type. The classifier has two modes. In version-1 mode it accepts a UDP packet to the configured port whose message code equals the configured code. In version-2 mode it accepts every version-2 event message, which are message types 0 to 3. These can arrive over UDP to the configured port, or as layer-2 frames with ethertype 0x88F7 when the layer-2 filter is switched on. On transmit, the MAC marks the packet that it wants stamped.

Top module: `ts_capture_latch`

## Requirements
- R1: After reset both valid flags are low and both stamps read zero.
- R2: In version-1 mode (rx_mode_i = 0) a receive packet is captured when all of the following hold: it is UDP, its destination port equals match_cfg_i[31:16], its version field is 1, and its message type equals match_cfg_i[3:0]. The stamp equals time_i on the cycle of the start strobe, and rx_valid_o is high from the following cycle.
- R3: In version-1 mode a packet with a different port, a different message code or a different version is not captured. A layer-2 frame is not captured either.
- R4: In version-2 mode (rx_mode_i = 1) a UDP packet to the configured port with version 2 is captured for every message type 0 to 3, whatever match_cfg_i[3:0] holds. Message types 4 to 15 and other versions are not captured.
- R5: In version-2 mode a layer-2 version-2 event frame is captured only when l2_filter_en_i is high and its ethertype is 0x88F7.
- R6: While a valid flag is high, no further capture takes place in that direction, and the stamp does not change.
- R7: A high-word read strobe while valid clears the flag on the next cycle. A later qualifying packet is then captured with its own time.
- R8: While a direction's enable is low its valid flag is cleared on the next cycle and no capture occurs.
- R9: The transmit side captures on tx_sop_i only when tx_stamp_req_i and tx_en_i are high. It works independently of the receive side.
- R10: If a high-word read and a qualifying start strobe come in the same cycle while the flag is set, the packet is dropped and the flag ends low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| time_i | input | 64 | System time value |
| rx_en_i | input | 1 | Receive capture enable |
| rx_mode_i | input | 1 | 0 = version-1 UDP mode, 1 = version-2 event mode |
| match_cfg_i | input | 32 | [31:16] event UDP port, [3:0] version-1 message code |
| l2_filter_en_i | input | 1 | Enable layer-2 ethertype matching |
| rx_sop_i | input | 1 | Receive packet start strobe |
| rx_is_l2_i | input | 1 | Packet is a raw layer-2 frame |
| rx_is_udp_i | input | 1 | Packet is UDP |
| rx_ethertype_i | input | 16 | Frame ethertype |
| rx_dport_i | input | 16 | UDP destination port |
| rx_ver_i | input | 4 | Protocol version field |
| rx_msg_type_i | input | 4 | Message type / code field |
| rx_rd_hi_i | input | 1 | Software read of receive high stamp word |
| tx_en_i | input | 1 | Transmit capture enable |
| tx_sop_i | input | 1 | Transmit packet start strobe |
| tx_stamp_req_i | input | 1 | Transmit packet is marked for stamping |
| tx_rd_hi_i | input | 1 | Software read of transmit high stamp word |
| rx_valid_o | output | 1 | Receive stamp held |
| rx_stamp_lo_o | output | 32 | Receive stamp low word |
| rx_stamp_hi_o | output | 32 | Receive stamp high word |
| tx_valid_o | output | 1 | Transmit stamp held |
| tx_stamp_lo_o | output | 32 | Transmit stamp low word |
| tx_stamp_hi_o | output | 32 | Transmit stamp high word |

## Verification
The hardest state to observe is the locked latch receiving another event. Nothing at the ports shows that the packet was dropped, except that the held stamp keeps its old time. The stimulus captures a packet, leaves it unread, sends a second qualifying packet at a different time, and then compares the stamp with the first time. A second case places a high-word read and a packet start in the same cycle. The classifier is swept over every message type, both versions, matching and mismatching ports, and both transports, in both modes.

// File: rtl/ts_pkg.sv
package ts_pkg;
  localparam int unsigned TIME_W = 64;
  localparam int unsigned WORD_W = 32;
  localparam logic [15:0] ETH_PTP = 16'h88F7;
  typedef enum logic { MODE_V1_L4 = 1'b0, MODE_V2_EVT = 1'b1 } rx_mode_e;
endpackage

// File: rtl/ts_rx_classifier.sv
module ts_rx_classifier
  import ts_pkg::*;
(
  input  logic        mode_i,
  input  logic [31:0] match_cfg_i,
  input  logic        l2_filter_en_i,
  input  logic        is_l2_i,
  input  logic        is_udp_i,
  input  logic [15:0] ethertype_i,
  input  logic [15:0] dport_i,
  input  logic [3:0]  ver_i,
  input  logic [3:0]  msg_type_i,
  output logic        hit_o
);
  logic port_ok, v1_hit, v2_evt, v2_hit;

  always_comb begin
    port_ok = is_udp_i && (dport_i == match_cfg_i[31:16]);
    v1_hit  = port_ok && (ver_i == 4'd1) && (msg_type_i == match_cfg_i[3:0]);
    // v2: all event types stamped, msg code field ignored
    v2_evt  = (ver_i == 4'd2) && (msg_type_i[3:2] == 2'b00);
    v2_hit  = v2_evt && (port_ok ||
              (l2_filter_en_i && is_l2_i && ethertype_i == ETH_PTP));
    hit_o   = (rx_mode_e'(mode_i) == MODE_V2_EVT) ? v2_hit : v1_hit;
  end

  always_comb begin
    if (!is_udp_i && !l2_filter_en_i)
      assert_no_hit_without_transport_R5: assert (!hit_o);
  end
endmodule

// File: rtl/ts_latch.sv
module ts_latch #(
  parameter int unsigned TIME_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              sop_i,
  input  logic              hit_i,
  input  logic              rd_hi_i,
  input  logic [TIME_W-1:0] time_i,
  output logic              valid_o,
  output logic [TIME_W-1:0] stamp_o
);
  logic              valid_q;
  logic [TIME_W-1:0] stamp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      stamp_q <= '0;
    end else if (!en_i) begin
      valid_q <= 1'b0;
    end else if (valid_q) begin
      if (rd_hi_i) valid_q <= 1'b0;
    end else if (sop_i && hit_i) begin
      valid_q <= 1'b1;
      stamp_q <= time_i;
    end
  end

  assign valid_o = valid_q;
  assign stamp_o = stamp_q;

  assert_capture_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && sop_i && hit_i && !valid_q) |=> (valid_q && stamp_q == $past(time_i)));
  assert_hold_stable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> $stable(stamp_q));
  assert_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && rd_hi_i) |=> !valid_q);
  assert_disable_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !valid_q);
endmodule

// File: rtl/ts_capture_latch.sv
module ts_capture_latch
  import ts_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TIME_W-1:0] time_i,
  input  logic              rx_en_i,
  input  logic              rx_mode_i,
  input  logic [31:0]       match_cfg_i,
  input  logic              l2_filter_en_i,
  input  logic              rx_sop_i,
  input  logic              rx_is_l2_i,
  input  logic              rx_is_udp_i,
  input  logic [15:0]       rx_ethertype_i,
  input  logic [15:0]       rx_dport_i,
  input  logic [3:0]        rx_ver_i,
  input  logic [3:0]        rx_msg_type_i,
  input  logic              rx_rd_hi_i,
  input  logic              tx_en_i,
  input  logic              tx_sop_i,
  input  logic              tx_stamp_req_i,
  input  logic              tx_rd_hi_i,
  output logic              rx_valid_o,
  output logic [WORD_W-1:0] rx_stamp_lo_o,
  output logic [WORD_W-1:0] rx_stamp_hi_o,
  output logic              tx_valid_o,
  output logic [WORD_W-1:0] tx_stamp_lo_o,
  output logic [WORD_W-1:0] tx_stamp_hi_o
);
  logic              rx_hit;
  logic [TIME_W-1:0] rx_stamp, tx_stamp;

  ts_rx_classifier u_cls (
    .mode_i        (rx_mode_i),
    .match_cfg_i   (match_cfg_i),
    .l2_filter_en_i(l2_filter_en_i),
    .is_l2_i       (rx_is_l2_i),
    .is_udp_i      (rx_is_udp_i),
    .ethertype_i   (rx_ethertype_i),
    .dport_i       (rx_dport_i),
    .ver_i         (rx_ver_i),
    .msg_type_i    (rx_msg_type_i),
    .hit_o         (rx_hit)
  );

  ts_latch #(.TIME_W(TIME_W)) u_rx_latch (
    .clk_i, .rst_ni,
    .en_i   (rx_en_i),
    .sop_i  (rx_sop_i),
    .hit_i  (rx_hit),
    .rd_hi_i(rx_rd_hi_i),
    .time_i (time_i),
    .valid_o(rx_valid_o),
    .stamp_o(rx_stamp)
  );

  ts_latch #(.TIME_W(TIME_W)) u_tx_latch (
    .clk_i, .rst_ni,
    .en_i   (tx_en_i),
    .sop_i  (tx_sop_i),
    .hit_i  (tx_stamp_req_i),
    .rd_hi_i(tx_rd_hi_i),
    .time_i (time_i),
    .valid_o(tx_valid_o),
    .stamp_o(tx_stamp)
  );

  assign rx_stamp_lo_o = rx_stamp[WORD_W-1:0];
  assign rx_stamp_hi_o = rx_stamp[TIME_W-1:WORD_W];
  assign tx_stamp_lo_o = tx_stamp[WORD_W-1:0];
  assign tx_stamp_hi_o = tx_stamp[TIME_W-1:WORD_W];

  assert_tx_no_req_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_valid_o && !(tx_sop_i && tx_stamp_req_i)) |=> !tx_valid_o);
endmodule

// File: tb/ts_capture_latch_bench.sv
module ts_capture_latch_bench;
  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic [63:0] t = 64'h1234_5678_0000_0100;
  always @(posedge clk) t <= t + 64'h0000_0001_0000_0007;

  logic rx_en = 0, rx_mode = 0, l2_en = 0, rx_sop = 0, is_l2 = 0, is_udp = 0, rx_rd = 0;
  logic [31:0] cfg = 0;
  logic [15:0] et = 0, dport = 0;
  logic [3:0] ver = 0, mt = 0;
  logic tx_en = 0, tx_sop = 0, tx_req = 0, tx_rd = 0;
  logic rx_v, tx_v;
  logic [31:0] rx_lo, rx_hi, tx_lo, tx_hi;

  int checks = 0, errors = 0;
  localparam logic [15:0] PORT = 16'd319;

  ts_capture_latch u_ts_capture_latch (
    .clk_i(clk), .rst_ni(rst_n), .time_i(t),
    .rx_en_i(rx_en), .rx_mode_i(rx_mode), .match_cfg_i(cfg), .l2_filter_en_i(l2_en),
    .rx_sop_i(rx_sop), .rx_is_l2_i(is_l2), .rx_is_udp_i(is_udp),
    .rx_ethertype_i(et), .rx_dport_i(dport), .rx_ver_i(ver), .rx_msg_type_i(mt),
    .rx_rd_hi_i(rx_rd), .tx_en_i(tx_en), .tx_sop_i(tx_sop), .tx_stamp_req_i(tx_req),
    .tx_rd_hi_i(tx_rd), .rx_valid_o(rx_v), .rx_stamp_lo_o(rx_lo), .rx_stamp_hi_o(rx_hi),
    .tx_valid_o(tx_v), .tx_stamp_lo_o(tx_lo), .tx_stamp_hi_o(tx_hi)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one rx packet; returns time sampled for capture
  task automatic rx_pkt(input bit l2, input bit udp, input logic [15:0] e, input logic [15:0] p,
                        input logic [3:0] v, input logic [3:0] m, output logic [63:0] ts);
    is_l2 = l2; is_udp = udp; et = e; dport = p; ver = v; mt = m;
    rx_sop = 1; ts = t;
    @(negedge clk);
    rx_sop = 0; is_l2 = 0; is_udp = 0;
  endtask

  task automatic rx_release();
    rx_rd = 1; @(negedge clk); rx_rd = 0;
  endtask

  function automatic bit exp_hit(input bit mode, input bit l2f, input bit l2, input bit udp,
                                 input logic [15:0] e, input logic [15:0] p,
                                 input logic [3:0] v, input logic [3:0] m);
    bit udp_ok = udp && (p == cfg[31:16]);
    if (!mode) return udp_ok && v == 1 && m == cfg[3:0];
    return (v == 2) && (m < 4) && (udp_ok || (l2f && l2 && e == 16'h88F7));
  endfunction

  task automatic sweep_one(input string req, input bit l2, input bit udp, input logic [15:0] e,
                           input logic [15:0] p, input logic [3:0] v, input logic [3:0] m);
    logic [63:0] ts;
    bit x;
    x = exp_hit(rx_mode, l2_en, l2, udp, e, p, v, m);
    rx_pkt(l2, udp, e, p, v, m, ts);
    chk(rx_v == x, req, {63'd0, rx_v}, {63'd0, x});
    if (x) begin
      chk({rx_hi, rx_lo} == ts, req, {rx_hi, rx_lo}, ts);
      rx_release();
      chk(rx_v == 0, "R7", {63'd0, rx_v}, 64'd0);
    end
  endtask

  bit done = 0;
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] t1, t2;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(rx_v == 0 && tx_v == 0, "R1", {62'd0, rx_v, tx_v}, 64'd0);
    chk({rx_hi, rx_lo, tx_hi, tx_lo} == 0, "R1", {rx_hi, rx_lo}, 64'd0);
    rst_n = 1;
    @(negedge clk);
    rx_en = 1; tx_en = 1;

    // R2/R3 version-1 mode sweep
    rx_mode = 0; cfg = {PORT, 16'h0001};
    for (int m = 0; m < 16; m++)
      for (int v = 1; v <= 2; v++) begin
        sweep_one("R2/R3 v1 udp", 0, 1, 16'h0800, PORT, v[3:0], m[3:0]);
        sweep_one("R3 v1 bad port", 0, 1, 16'h0800, PORT + 16'd1, v[3:0], m[3:0]);
      end
    l2_en = 1;
    sweep_one("R3 v1 l2 frame", 1, 0, 16'h88F7, PORT, 4'd1, 4'd1);
    sweep_one("R2 v1 exact", 0, 1, 16'h0800, PORT, 4'd1, 4'd1);

    // R4/R5 version-2 mode sweep
    rx_mode = 1; cfg = {PORT, 16'h000B};
    for (int f = 0; f < 2; f++) begin
      l2_en = f[0];
      for (int m = 0; m < 16; m++) begin
        sweep_one("R4 v2 udp", 0, 1, 16'h0800, PORT, 4'd2, m[3:0]);
        sweep_one("R4 v2 bad port", 0, 1, 16'h0800, 16'd320, 4'd2, m[3:0]);
        sweep_one("R4 v2 wrong ver", 0, 1, 16'h0800, PORT, 4'd1, m[3:0]);
        sweep_one("R5 v2 l2", 1, 0, 16'h88F7, 16'd0, 4'd2, m[3:0]);
        sweep_one("R5 v2 l2 bad et", 1, 0, 16'h88F8, 16'd0, 4'd2, m[3:0]);
      end
    end

    // R6 hold while valid
    l2_en = 1;
    rx_pkt(0, 1, 16'h0800, PORT, 4'd2, 4'd0, t1);
    repeat (2) @(negedge clk);
    rx_pkt(1, 0, 16'h88F7, 16'd0, 4'd2, 4'd1, t2);
    chk(rx_v == 1, "R6", {63'd0, rx_v}, 64'd1);
    chk({rx_hi, rx_lo} == t1, "R6", {rx_hi, rx_lo}, t1);
    // R10 same-cycle read and packet
    rx_rd = 1;
    rx_pkt(0, 1, 16'h0800, PORT, 4'd2, 4'd3, t2);
    rx_rd = 0;
    chk(rx_v == 0, "R10", {63'd0, rx_v}, 64'd0);
    chk({rx_hi, rx_lo} == t1, "R10", {rx_hi, rx_lo}, t1);
    // R7 next capture after release
    rx_pkt(0, 1, 16'h0800, PORT, 4'd2, 4'd3, t2);
    chk(rx_v == 1 && {rx_hi, rx_lo} == t2, "R7", {rx_hi, rx_lo}, t2);

    // R8 disable clears and blocks
    rx_en = 0; @(negedge clk);
    chk(rx_v == 0, "R8", {63'd0, rx_v}, 64'd0);
    rx_pkt(0, 1, 16'h0800, PORT, 4'd2, 4'd0, t1);
    chk(rx_v == 0, "R8", {63'd0, rx_v}, 64'd0);
    chk({rx_hi, rx_lo} == t2, "R8", {rx_hi, rx_lo}, t2);
    rx_en = 1;

    // R9 transmit side
    tx_req = 0; tx_sop = 1; @(negedge clk); tx_sop = 0;
    chk(tx_v == 0, "R9", {63'd0, tx_v}, 64'd0);
    tx_req = 1; tx_sop = 1; t1 = t; @(negedge clk); tx_sop = 0; tx_req = 0;
    chk(tx_v == 1 && {tx_hi, tx_lo} == t1, "R9", {tx_hi, tx_lo}, t1);
    chk(rx_v == 0, "R9", {63'd0, rx_v}, 64'd0);
    tx_req = 1; tx_sop = 1; @(negedge clk); tx_sop = 0; tx_req = 0;
    chk({tx_hi, tx_lo} == t1, "R6", {tx_hi, tx_lo}, t1);
    tx_rd = 1; @(negedge clk); tx_rd = 0;
    chk(tx_v == 0, "R7", {63'd0, tx_v}, 64'd0);
    tx_en = 0; tx_req = 1; tx_sop = 1; @(negedge clk); tx_sop = 0; tx_req = 0;
    chk(tx_v == 0, "R8", {63'd0, tx_v}, 64'd0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule